// File: doc/BRIEF.md
# I2C Slave Address Matcher with Software-Paced Byte Handshake

This block is the target side of an I2C bus. It samples the SCL and SDA lines, finds start and stop conditions, and shifts in the address byte that follows a start. It compares that byte with four programmable address slots. Slot 0 also has a don't-care mask. When a slot matches, the engine stretches the clock and raises a pending flag. Software then reads the coded state, the index of the winning slot and the received byte. It answers by writing a control register. The answer either acknowledges the byte and releases the clock, or refuses it.

A write transfer hands each received byte to software in the same way. In a read transfer the engine asks software for every byte it must send. It keeps sending bytes as long as the master acknowledges them. Ten-bit addressing is not supported. The block drives the lines only by pulling them low, through two output-enable pins.

Register writes use a small select/data port. Select 0 to 3 are the address slots, 4 is the slot-0 mask, 5 is the transmit byte and 6 is the control register.

Top module: `i2c_slave_match_eng`

## Requirements
- R1: A slot holds a 7-bit address in bits 7:1. An address byte whose bits 7:1 equal an enabled slot's address raises pending with state 0, and the data output then shows the whole address byte including the R/W bit 0. Slots are written at select 0 to 3.
- R2: A slot whose bit 0 is 1 is disabled. An address aimed only at disabled slots raises no pending and is not acknowledged: SDA stays released in the ninth clock.
- R3: The mask register at select 4 applies to slot 0 only. A 1 in mask bit k (k = 7..1) makes address bit k always match. With the mask at 0, slot 0 compares every bit.
- R4: A slot loaded with 0x00 matches the general call byte 0x00.
- R5: Status bits 13:12 give the index (0 to 3) of the matching slot. When several slots match, the lowest index wins.
- R6: Status bit 8 is pending. Status bits 10:9 give the state: 0 = address received, 1 = data received, 2 = transmit byte wanted (3 is never reported). After reset the status word is 0 and neither line is pulled.
- R7: While pending is set, the block holds SCL low. A control write that answers the byte releases SCL.
- R8: Writing the control register at select 6 with bit 0 set (continue) acknowledges a received byte: SDA is pulled low in the ninth clock. Writing it with bit 1 set (refuse) leaves SDA released and ends the transfer; bytes that follow are ignored, with no pending and no acknowledge, until the next start. Bit 1 wins if both are set.
- R9: In a write transfer, every received data byte raises pending with state 1, and the data output holds that byte.
- R10: After a read address is acknowledged, pending is raised with state 2. Software loads the byte at select 5 and writes continue, and the byte is shifted out MSB first.
- R11: A master acknowledge of a sent byte raises pending with state 2 again. A master refusal ends the transfer, and no further byte is requested.
- R12: A start seen in the middle of a transfer (a repeated start) restarts address reception. A matching address reports state 0 again.
- R13: A stop condition clears pending, releases both lines and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0-3 slots, 4 mask, 5 transmit, 6 control) |
| reg_wdata | input | 8 | Register write data |
| stat_o | output | 16 | Status word (pending, state, slot index) |
| rdata_o | output | 8 | Last received address or data byte |

## Verification
The bus is driven by an open-drain master model that waits out clock stretching. A software model answers each pending event from a queue of expected events.

The address patterns are chosen so that each one tells a different matching rule apart:
- an address reachable only through the slot-0 mask;
- an address that matches both slot 0 and slot 2, to check priority;
- the same address with the mask cleared, so that only slot 2 matches;
- the general call byte;
- an address whose only slot is disabled, tried again after the slot is enabled.

The transfers cover several cases. A write stream ends with a refused byte, and the bytes after it must be ignored. A read stream ends with a master refusal. A repeated start changes direction in the middle of a transfer. A stop arrives during data reception.

// File: rtl/i2c_sl_pkg.sv
package i2c_sl_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int SEL_W     = 3;

    localparam logic [SEL_W-1:0] SEL_MASK = 3'd4;
    localparam logic [SEL_W-1:0] SEL_TXD  = 3'd5;
    localparam logic [SEL_W-1:0] SEL_CTL  = 3'd6;

    localparam logic [1:0] ST_ADDR = 2'd0;
    localparam logic [1:0] ST_RX   = 2'd1;
    localparam logic [1:0] ST_TX   = 2'd2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_BEND,
        PH_HOLD,
        PH_ACK,
        PH_SEND,
        PH_MACK
    } phase_e;

    typedef struct packed {
        phase_e           ph;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             addr_ph;
        logic             rd;
        logic             mnak;
        logic             hold;
        logic [1:0]       st;
        logic [IDX_W-1:0] idx;
    } core_t;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][7:0] slot;
        logic [6:0]                mask;
        logic [7:0]                tx;
    } cfg_t;
endpackage

// File: rtl/i2c_sl_linemon.sv
module i2c_sl_linemon #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_N-1:0] scl_q, sda_q;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= '1;
            sda_q      <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_q      <= {scl_q[SYNC_N-2:0], scl_i};
            sda_q      <= {sda_q[SYNC_N-2:0], sda_i};
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_s     = scl_q[SYNC_N-1];
    assign sda_s     = sda_q[SYNC_N-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/i2c_sl_addrmatch.sv
module i2c_sl_addrmatch
    import i2c_sl_pkg::*;
(
    input  logic [NUM_SLOTS-1:0][7:0] slot_i,
    input  logic [6:0]                mask_i,
    input  logic [6:0]                addr_i,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          idx_o
);
    logic [NUM_SLOTS-1:0] hit_v;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            logic [6:0] dc;
            if (g == 0) begin : g_masked
                assign dc = mask_i;
            end else begin : g_exact
                assign dc = 7'd0;
            end
            assign hit_v[g] = !slot_i[g][0] &&
                              (((slot_i[g][7:1] ^ addr_i) & ~dc) == 7'd0);
        end
    endgenerate

    always_comb begin
        hit_o = |hit_v;
        idx_o = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (hit_v[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/i2c_sl_core.sv
module i2c_sl_core
    import i2c_sl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic [7:0]       tx_byte,
    input  logic             ctl_go,
    input  logic             ctl_nack,
    output logic [7:0]       shift_o,
    output logic [7:0]       rx_o,
    output logic             pend_o,
    output logic [1:0]       st_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             scl_pull,
    output logic             sda_pull
);
    core_t q, d;

    always_comb begin
        d      = q;
        d.hold = (q.ph == PH_HOLD);
        unique case (q.ph)
            PH_IDLE: ;
            PH_RECV: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[6:0], sda_s};
                    d.cnt = q.cnt + 4'd1;
                    if (q.cnt == 4'd7) d.ph = PH_BEND;
                end
            end
            PH_BEND: begin
                if (scl_fall) begin
                    if (q.addr_ph) begin
                        if (hit) begin
                            d.rx  = q.sh;
                            d.rd  = q.sh[0];
                            d.idx = hit_idx;
                            d.st  = ST_ADDR;
                            d.ph  = PH_HOLD;
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end else begin
                        d.rx = q.sh;
                        d.st = ST_RX;
                        d.ph = PH_HOLD;
                    end
                end
            end
            PH_HOLD: begin
                if (ctl_nack) begin
                    d.ph = PH_IDLE;
                end else if (ctl_go) begin
                    if (q.st == ST_TX) begin
                        d.ph  = PH_SEND;
                        d.cnt = 4'd0;
                        d.sh  = tx_byte;
                    end else begin
                        d.ph = PH_ACK;
                    end
                end
            end
            PH_ACK: begin
                if (scl_fall) begin
                    if (q.addr_ph && q.rd) begin
                        d.ph = PH_HOLD;
                        d.st = ST_TX;
                    end else begin
                        d.ph  = PH_RECV;
                        d.cnt = 4'd0;
                    end
                    d.addr_ph = 1'b0;
                end
            end
            PH_SEND: begin
                if (scl_fall) begin
                    d.sh  = {q.sh[6:0], 1'b1};
                    d.cnt = q.cnt + 4'd1;
                    if (q.cnt == 4'd7) d.ph = PH_MACK;
                end
            end
            PH_MACK: begin
                if (scl_rise) d.mnak = sda_s;
                if (scl_fall) begin
                    if (!q.mnak) begin
                        d.ph = PH_HOLD;
                        d.st = ST_TX;
                    end else begin
                        d.ph = PH_IDLE;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
        if (start_det) begin
            d.ph      = PH_RECV;
            d.cnt     = 4'd0;
            d.addr_ph = 1'b1;
        end else if (stop_det) begin
            d.ph = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, cnt: '0, sh: '0, rx: '0, addr_ph: 1'b0, rd: 1'b0,
                   mnak: 1'b0, hold: 1'b0, st: ST_ADDR, idx: '0};
        end else begin
            q <= d;
        end
    end

    assign shift_o  = q.sh;
    assign rx_o     = q.rx;
    assign pend_o   = (q.ph == PH_HOLD);
    assign st_o     = pend_o ? q.st : ST_ADDR;
    assign idx_o    = pend_o ? q.idx : '0;
    assign scl_pull = (q.ph == PH_HOLD) || q.hold;
    assign sda_pull = (q.ph == PH_ACK) || ((q.ph == PH_SEND) && !q.sh[7]);
endmodule

// File: rtl/i2c_slave_match_eng.sv
module i2c_slave_match_eng
    import i2c_sl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [15:0]      stat_o,
    output logic [7:0]       rdata_o
);
    cfg_t cfg_q, cfg_d;

    logic                 sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic                 hit, pend, ctl_we, ctl_go, ctl_nack;
    logic [IDX_W-1:0]     hit_idx, idx;
    logic [1:0]           st;
    logic [7:0]           shift;
    logic [NUM_SLOTS-1:0] slot_dis;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_we) begin
            if (reg_sel < SEL_W'(NUM_SLOTS)) cfg_d.slot[reg_sel[IDX_W-1:0]] = reg_wdata;
            else if (reg_sel == SEL_MASK)    cfg_d.mask = reg_wdata[7:1];
            else if (reg_sel == SEL_TXD)     cfg_d.tx   = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{slot: {NUM_SLOTS{8'h01}}, mask: '0, tx: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ctl_we   = reg_we && (reg_sel == SEL_CTL);
    assign ctl_go   = ctl_we && reg_wdata[0];
    assign ctl_nack = ctl_we && reg_wdata[1];

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dis
            assign slot_dis[g] = cfg_q.slot[g][0];
        end
    endgenerate

    i2c_sl_linemon #(.SYNC_N(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_sl_addrmatch u_match (
        .slot_i(cfg_q.slot), .mask_i(cfg_q.mask), .addr_i(shift[7:1]),
        .hit_o(hit), .idx_o(hit_idx)
    );

    i2c_sl_core u_core (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .hit(hit), .hit_idx(hit_idx), .tx_byte(cfg_q.tx),
        .ctl_go(ctl_go), .ctl_nack(ctl_nack), .shift_o(shift),
        .rx_o(rdata_o), .pend_o(pend), .st_o(st), .idx_o(idx),
        .scl_pull(scl_oe), .sda_pull(sda_oe)
    );

    always_comb begin
        stat_o        = '0;
        stat_o[8]     = pend;
        stat_o[10:9]  = st;
        stat_o[13:12] = idx;
    end
endmodule

module i2c_sl_match_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] stat,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        start_det,
    input logic        stop_det,
    input logic        ctl_we,
    input logic [3:0]  slot_dis
);
    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        stat[8] |-> (stat[10:9] != 2'd3)); // R6

    AST_SCL_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        stat[8] |-> scl_oe); // R7

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[8] && !ctl_we && !start_det && !stop_det) |=> stat[8]); // R7

    AST_ENTER_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[8]) |-> !sda_oe); // R8

    AST_IDX_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[8] && stat[10:9] == 2'd0) |-> !slot_dis[stat[13:12]]); // R2

    AST_START_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !stat[8]); // R12

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!stat[8] && !sda_oe)); // R13
endmodule

bind i2c_slave_match_eng i2c_sl_match_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stat(stat_o), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .start_det(start_det), .stop_det(stop_det), .ctl_we(ctl_we), .slot_dis(slot_dis)
);

// File: tb/i2c_slave_match_eng_test.sv
module i2c_slave_match_eng_test;
    localparam int H = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b0, m_sda = 1'b0;
    logic        scl_oe, sda_oe;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] stat_o;
    logic [7:0]  rdata_o;
    wire         scl_line = ~(m_scl | scl_oe);
    wire         sda_line = ~(m_sda | sda_oe);

    int total = 0, bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] st;
        logic [1:0] idx;
        logic [7:0] dat;
        logic [1:0] ctl;
        logic [7:0] tx;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    i2c_slave_match_eng uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_o(stat_o), .rdata_o(rdata_o)
    );

    function automatic void chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic push(input logic [1:0] st, input logic [1:0] idx, input logic [7:0] dat,
                        input logic [1:0] ctl, input logic [7:0] tx);
        exp_t e;
        e.st = st; e.idx = idx; e.dat = dat; e.ctl = ctl; e.tx = tx;
        expq.push_back(e);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wait_n(H);
        m_scl = 1'b1; wait_n(H);
    endtask

    task automatic m_rstart();
        m_sda = 1'b0; wait_n(H);
        m_scl = 1'b0; wait_scl_high(); wait_n(H);
        m_start();
    endtask

    task automatic m_stop();
        m_sda = 1'b1; wait_n(H);
        m_scl = 1'b0; wait_scl_high(); wait_n(H);
        m_sda = 1'b0; wait_n(H);
    endtask

    task automatic m_bit_out(input logic b);
        m_sda = ~b; wait_n(H);
        m_scl = 1'b0; wait_scl_high(); wait_n(H);
        m_scl = 1'b1; wait_n(H / 2);
    endtask

    task automatic m_bit_in(output logic b);
        m_sda = 1'b0; wait_n(H);
        m_scl = 1'b0; wait_scl_high(); wait_n(H / 2);
        b = sda_line; wait_n(H / 2);
        m_scl = 1'b1; wait_n(H / 2);
    endtask

    task automatic m_wbyte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        for (int i = 7; i >= 0; i--) m_bit_out(b[i]);
        m_bit_in(a);
        chk(a == exp_ack, tag, int'(a), int'(exp_ack));
    endtask

    task automatic m_rbyte(input logic [7:0] exp, input logic mack, input string tag);
        logic [7:0] got;
        logic       b;
        for (int i = 7; i >= 0; i--) begin
            m_bit_in(b);
            got[i] = b;
        end
        chk(got == exp, tag, int'(got), int'(exp));
        m_bit_out(mack);
    endtask

    // monitor: plays the software side and scores every pending event
    initial begin
        exp_t e;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (stat_o[8]) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R6 unexpected pending", int'(stat_o), 0);
                    reg_write(3'd6, 8'h02);
                end else begin
                    e = expq.pop_front();
                    chk(stat_o[10:9] == e.st, "R6 state code", int'(stat_o[10:9]), int'(e.st));
                    chk(stat_o[13:12] == e.idx, "R5 slot index", int'(stat_o[13:12]), int'(e.idx));
                    chk(scl_oe == 1'b1, "R7 scl held while pending", int'(scl_oe), 1);
                    if (e.st != 2'd2)
                        chk(rdata_o == e.dat, "R1 R9 received byte", int'(rdata_o), int'(e.dat));
                    if (e.st == 2'd2) reg_write(3'd5, e.tx);
                    reg_write(3'd6, {6'd0, e.ctl});
                    wait_n(3);
                    chk(scl_oe == 1'b0, "R7 scl released after answer", int'(scl_oe), 0);
                end
                while (stat_o[8]) @(negedge clk);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        chk(stat_o == 16'h0, "R6 reset status", int'(stat_o), 0);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R6 reset lines free", int'({scl_oe, sda_oe}), 0);

        reg_write(3'd0, 8'h40);
        reg_write(3'd1, 8'h00);
        reg_write(3'd2, 8'h44);
        reg_write(3'd3, 8'h91);
        reg_write(3'd4, 8'h06);

        // write stream through the masked slot 0, refused byte, then ignored byte
        push(2'd0, 2'd0, 8'h42, 2'd1, 8'h00);
        push(2'd1, 2'd0, 8'h5A, 2'd1, 8'h00);
        push(2'd1, 2'd0, 8'hC3, 2'd2, 8'h00);
        m_start();
        m_wbyte(8'h42, 1'b0, "R1 R3 masked address acked");
        m_wbyte(8'h5A, 1'b0, "R9 data byte acked");
        m_wbyte(8'hC3, 1'b1, "R8 refused byte");
        m_wbyte(8'h11, 1'b1, "R8 byte after refusal ignored");
        chk(stat_o == 16'h0, "R8 no pending after refusal", int'(stat_o), 0);
        m_stop();
        chk(expq.size() == 0, "R9 all events seen", expq.size(), 0);

        // read stream: 0x22 matches slot 0 (masked) and slot 2, lowest wins
        push(2'd0, 2'd0, 8'h45, 2'd1, 8'h00);
        push(2'd2, 2'd0, 8'h00, 2'd1, 8'hA5);
        push(2'd2, 2'd0, 8'h00, 2'd1, 8'h3C);
        m_start();
        m_wbyte(8'h45, 1'b0, "R5 read address acked");
        m_rbyte(8'hA5, 1'b0, "R10 first sent byte");
        m_rbyte(8'h3C, 1'b1, "R11 second sent byte");
        wait_n(4 * H);
        chk(stat_o[8] == 1'b0 && sda_oe == 1'b0, "R11 no request after master refusal",
            int'({stat_o[8], sda_oe}), 0);
        m_stop();
        chk(expq.size() == 0, "R11 all events seen", expq.size(), 0);

        // general call, then repeated start into a read
        push(2'd0, 2'd1, 8'h00, 2'd1, 8'h00);
        push(2'd1, 2'd1, 8'h77, 2'd1, 8'h00);
        m_start();
        m_wbyte(8'h00, 1'b0, "R4 general call acked");
        m_wbyte(8'h77, 1'b0, "R9 general call data");
        push(2'd0, 2'd0, 8'h41, 2'd1, 8'h00);
        push(2'd2, 2'd0, 8'h00, 2'd1, 8'hF0);
        m_rstart();
        m_wbyte(8'h41, 1'b0, "R12 repeated start address");
        m_rbyte(8'hF0, 1'b1, "R12 byte after repeated start");
        m_stop();
        chk(expq.size() == 0, "R12 all events seen", expq.size(), 0);

        // disabled slot, then mask cleared and slot enabled
        m_start();
        m_wbyte(8'h90, 1'b1, "R2 disabled slot not acked");
        chk(stat_o == 16'h0, "R2 no pending for disabled slot", int'(stat_o), 0);
        m_stop();
        reg_write(3'd3, 8'h90);
        reg_write(3'd4, 8'h00);
        push(2'd0, 2'd2, 8'h44, 2'd1, 8'h00);
        m_start();
        m_wbyte(8'h44, 1'b0, "R3 unmasked slot 2 wins");
        m_stop();
        push(2'd0, 2'd3, 8'h90, 2'd1, 8'h00);
        m_start();
        m_wbyte(8'h90, 1'b0, "R2 enabled slot 3 acked");
        m_bit_out(1'b1);
        m_bit_out(1'b0);
        m_stop();
        wait_n(4);
        chk(stat_o == 16'h0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R13 stop returns to idle",
            int'({stat_o[8], scl_oe, sda_oe}), 0);
        chk(expq.size() == 0, "R13 all events seen", expq.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule